// File: doc/BRIEF.md
# Page-Aligned Flash Write Segmenter

This block plans a flash write. It takes a start address and a byte count of up to 65535. It cuts the request into page-program chunks, and no chunk spans a 256-byte page boundary. Each chunk leaves the block as a start address and a length on a valid/ready handshake towards a downstream flash sequencer. Each chunk also carries its sector number (address divided by 4096), its offset inside that sector (address modulo 4096) and a flag that marks the final chunk. A one-cycle completion pulse follows once the whole request has been handed off.

Alongside the segmenter, an optional blank checker watches a stream of bytes read back from the target region. Only bytes that the caller marks as inside the compared window count. Any such byte other than 0xFF raises a sticky erase-required flag, because programming is only reliable on erased cells. A clear pulse starts each new check.

The controller has three states. `S_IDLE` accepts a request. `S_ISSUE` presents the current chunk. `S_FIN` pulses completion. The transitions are:
- `S_IDLE`→`S_ISSUE` on a request with a non-zero count.
- `S_IDLE`→`S_FIN` on a zero-length request.
- `S_ISSUE`→`S_ISSUE` on a handshake of a chunk that is not the final one.
- `S_ISSUE`→`S_FIN` on the handshake of the final chunk.
- `S_FIN`→`S_IDLE` always.

Top module: `flash_page_splitter`

## Requirements
- R1: After reset, `req_ready`=1, `chk_valid`=0, `seg_done`=0 and `erase_need`=0.
- R2: The cycle after a request with a non-zero count is accepted, the first chunk is presented at the start address. Its length is the smaller of the count and 256 minus (address mod 256).
- R3: After each accepted chunk that is not final, the next chunk's address is the previous address plus the previous length. Its length is 256 while more than 256 bytes remain, and otherwise the remaining count.
- R4: For every presented chunk, (address mod 256) + length ≤ 256, and the length is at least 1.
- R5: `chk_last`=1 exactly on the chunk whose length equals the bytes still remaining. `seg_done` pulses for one cycle in the cycle after that chunk's handshake.
- R6: A zero-count request produces no chunk, and `seg_done` pulses in the cycle after acceptance.
- R7: While `chk_valid`=1 and `chk_ready`=0, the chunk address and length stay unchanged in the next cycle, and `chk_valid` stays 1.
- R8: `req_ready` is 0 from acceptance until `seg_done` has pulsed. A request offered during that time has no effect on the chunks produced.
- R9: `chk_sector` equals `chk_addr` divided by 4096, and `chk_sec_off` equals `chk_addr` mod 4096.
- R10: `scan_clr` forces `erase_need` to 0 in the next cycle, and it takes priority over a byte offered in the same cycle. A byte with `scan_vld`=1, `scan_inwin`=1 and a value other than 0xFF sets `erase_need` in the next cycle. The flag then stays set until the next `scan_clr`.
- R11: A byte of 0xFF, or a byte with `scan_inwin`=0, leaves `erase_need` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_addr | input | 24 | Start byte address of the write |
| req_len | input | 16 | Byte count of the write |
| req_ready | output | 1 | Block can accept a request |
| chk_valid | output | 1 | Chunk descriptor presented |
| chk_ready | input | 1 | Downstream takes the chunk |
| chk_addr | output | 24 | Chunk start address |
| chk_len | output | 9 | Chunk length, 1 to 256 |
| chk_last | output | 1 | Final chunk of the request |
| chk_sector | output | 12 | Sector number of the chunk start |
| chk_sec_off | output | 12 | Offset of the chunk start in its sector |
| seg_done | output | 1 | One-cycle pulse when the request is fully segmented |
| scan_clr | input | 1 | Starts a new blank check |
| scan_vld | input | 1 | Read-back byte present |
| scan_data | input | 8 | Read-back byte |
| scan_inwin | input | 1 | Byte lies inside the compared window |
| erase_need | output | 1 | Sticky flag: sector erase required |

## Verification
A wrong remaining count or chunk length shows up on the first chunk it touches. It appears as a length that breaks the page bound, an address that does not continue from the previous chunk, or `chk_last` and `seg_done` coming one chunk early or late. The chunk address and length are registered, so such a fault is visible in the cycle after the handshake that caused it. A state held wrongly under back-pressure shows as a changed descriptor while `chk_ready` is low. A blank-check fault shows in `erase_need` one cycle after the offending byte or clear.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_FIN   = 2'd2
    } seg_state_t;
endpackage

// File: rtl/fps_len_calc.sv
module fps_len_calc #(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 256,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int LEN_W     = PG_W + 1
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [CNT_W-1:0]  rem_after,
    output logic [LEN_W-1:0]  first_len,
    output logic [LEN_W-1:0]  next_len
);
    logic [CNT_W-1:0] room;

    // bytes left in the page that holds the start address
    always_comb begin
        room = CNT_W'(PAGE_BYTES) - CNT_W'(start_addr[PG_W-1:0]);
        if (start_cnt < room)
            first_len = LEN_W'(start_cnt);
        else
            first_len = LEN_W'(room);
    end

    // later chunks start page-aligned: full page or the tail
    always_comb begin
        if (rem_after > CNT_W'(PAGE_BYTES))
            next_len = LEN_W'(PAGE_BYTES);
        else
            next_len = LEN_W'(rem_after);
    end
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 256,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int LEN_W     = PG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_len,
    output logic              req_ready,
    output logic              chk_valid,
    input  logic              chk_ready,
    output logic [ADDR_W-1:0] chk_addr,
    output logic [LEN_W-1:0]  chk_len,
    output logic              chk_last,
    output logic              seg_done,
    input  logic [LEN_W-1:0]  first_len,
    input  logic [LEN_W-1:0]  next_len,
    output logic [CNT_W-1:0]  rem_after
);
    seg_state_t       state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  rem;
    logic [LEN_W-1:0]  cur_len;
    logic              accept, take;

    assign accept    = (state == S_IDLE) && req_valid;
    assign take      = (state == S_ISSUE) && chk_ready;
    assign chk_last  = (rem == CNT_W'(cur_len));
    assign rem_after = rem - CNT_W'(cur_len);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = (req_len == '0) ? S_FIN : S_ISSUE;
            S_ISSUE: if (chk_ready && chk_last) state_nx = S_FIN;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        chk_valid = 1'b0;
        seg_done  = 1'b0;
        unique case (state)
            S_IDLE:  req_ready = 1'b1;
            S_ISSUE: chk_valid = 1'b1;
            S_FIN:   seg_done  = 1'b1;
            default: ;
        endcase
    end

    // chunk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem      <= '0;
            cur_len  <= '0;
        end else if (accept) begin
            cur_addr <= req_addr;
            rem      <= req_len;
            cur_len  <= first_len;
        end else if (take && !chk_last) begin
            cur_addr <= cur_addr + ADDR_W'(cur_len);
            rem      <= rem_after;
            cur_len  <= next_len;
        end
    end

    assign chk_addr = cur_addr;
    assign chk_len  = cur_len;

    // R2
    first_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len != '0) |=> (chk_valid && chk_addr == $past(req_addr)));
    // R3
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_ready && !chk_last) |=>
        (chk_valid && chk_addr == $past(chk_addr) + ADDR_W'($past(chk_len))));
    // R4
    page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> ((LEN_W+1)'(chk_addr[PG_W-1:0]) + (LEN_W+1)'(chk_len) <= (LEN_W+1)'(PAGE_BYTES)
                       && chk_len != '0));
    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_ready && chk_last) |=> seg_done);
    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> (seg_done && !chk_valid));
    // R7
    hold_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_addr) && $stable(chk_len)));
    // R8
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |=> req_ready);
endmodule

// File: rtl/fps_blank_scan.sv
module fps_blank_scan #(
    parameter int DATA_W = 8,
    parameter bit SCAN_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_clr,
    input  logic              scan_vld,
    input  logic [DATA_W-1:0] scan_data,
    input  logic              scan_inwin,
    output logic              erase_need
);
    logic hit;
    assign hit = scan_vld && scan_inwin && (scan_data != {DATA_W{1'b1}});

    generate
        if (SCAN_EN) begin : g_scan
            logic flag_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (scan_clr)
                    flag_q <= 1'b0;
                else if (hit)
                    flag_q <= 1'b1;
            end
            assign erase_need = flag_q;

            // R10
            set_on_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && !scan_clr) |=> erase_need);
            // R10
            clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                scan_clr |=> !erase_need);
            // R11
            sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!hit && !scan_clr) |=> (erase_need == $past(erase_need)));
        end else begin : g_noscan
            assign erase_need = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/flash_page_splitter.sv
module flash_page_splitter #(
    parameter int ADDR_W       = 24,
    parameter int CNT_W        = 16,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int DATA_W       = 8,
    parameter bit SCAN_EN      = 1'b1,
    localparam int PG_W        = $clog2(PAGE_BYTES),
    localparam int LEN_W       = PG_W + 1,
    localparam int SEC_W       = $clog2(SECTOR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [CNT_W-1:0]        req_len,
    output logic                    req_ready,
    output logic                    chk_valid,
    input  logic                    chk_ready,
    output logic [ADDR_W-1:0]       chk_addr,
    output logic [LEN_W-1:0]        chk_len,
    output logic                    chk_last,
    output logic [ADDR_W-SEC_W-1:0] chk_sector,
    output logic [SEC_W-1:0]        chk_sec_off,
    output logic                    seg_done,
    input  logic                    scan_clr,
    input  logic                    scan_vld,
    input  logic [DATA_W-1:0]       scan_data,
    input  logic                    scan_inwin,
    output logic                    erase_need
);
    logic [LEN_W-1:0] first_len, next_len;
    logic [CNT_W-1:0] rem_after;

    fps_len_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) calc_i (
        .start_addr (req_addr),
        .start_cnt  (req_len),
        .rem_after  (rem_after),
        .first_len  (first_len),
        .next_len   (next_len)
    );

    fps_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_ready  (req_ready),
        .chk_valid  (chk_valid),
        .chk_ready  (chk_ready),
        .chk_addr   (chk_addr),
        .chk_len    (chk_len),
        .chk_last   (chk_last),
        .seg_done   (seg_done),
        .first_len  (first_len),
        .next_len   (next_len),
        .rem_after  (rem_after)
    );

    fps_blank_scan #(.DATA_W(DATA_W), .SCAN_EN(SCAN_EN)) scan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_clr   (scan_clr),
        .scan_vld   (scan_vld),
        .scan_data  (scan_data),
        .scan_inwin (scan_inwin),
        .erase_need (erase_need)
    );

    // sector split of the chunk start (R9)
    assign chk_sector  = chk_addr[ADDR_W-1:SEC_W];
    assign chk_sec_off = chk_addr[SEC_W-1:0];
endmodule

// File: tb/flash_page_splitter_tb.sv
module flash_page_splitter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_ready;
    logic        chk_valid;
    logic        chk_ready = 1'b1;
    logic [23:0] chk_addr;
    logic [8:0]  chk_len;
    logic        chk_last;
    logic [11:0] chk_sector;
    logic [11:0] chk_sec_off;
    logic        seg_done;
    logic        scan_clr = 1'b0;
    logic        scan_vld = 1'b0;
    logic [7:0]  scan_data = 8'hFF;
    logic        scan_inwin = 1'b0;
    logic        erase_need;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    flash_page_splitter dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ready(req_ready), .chk_valid(chk_valid),
        .chk_ready(chk_ready), .chk_addr(chk_addr), .chk_len(chk_len),
        .chk_last(chk_last), .chk_sector(chk_sector), .chk_sec_off(chk_sec_off),
        .seg_done(seg_done), .scan_clr(scan_clr), .scan_vld(scan_vld),
        .scan_data(scan_data), .scan_inwin(scan_inwin), .erase_need(erase_need)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {start address, byte count}
    localparam int NV = 9;
    localparam logic [39:0] VEC [NV] = '{
        {24'h000000, 16'd1},
        {24'h0000FF, 16'd2},
        {24'h000010, 16'd256},
        {24'h000100, 16'd256},
        {24'h0001F0, 16'd600},
        {24'h123456, 16'd0},
        {24'hFFFF80, 16'd128},
        {24'h000FF0, 16'd40},
        {24'h000000, 16'd65535}
    };

    // offers one request and walks all chunks against a reference model
    task automatic run_req(input logic [23:0] a, input logic [15:0] n);
        logic [23:0] ea;
        int          er, el, room, cnt;
        ea = a; er = n; cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = n;
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (seg_done) break;
            if (chk_valid) begin
                room = 256 - int'(ea[7:0]);
                el = (er < room) ? er : room;
                // R2 first chunk / R3 later chunks
                check(chk_addr == ea && int'(chk_len) == el, cnt == 0 ? "R2" : "R3",
                      {chk_addr, 7'd0, chk_len}, {ea, 7'd0, 9'(el)});
                // R5
                check(chk_last == (er == el), "R5", chk_last, er == el);
                // R9
                check(chk_sector == ea[23:12] && chk_sec_off == ea[11:0], "R9",
                      {chk_sector, chk_sec_off}, ea);
                ea = ea + 24'(el); er = er - el; cnt++;
            end
            @(negedge clk);
        end
        // R5 / R6: done only after all bytes handed off
        check(er == 0, n == 0 ? "R6" : "R5", er, 0);
        if (n == 0) check(cnt == 0, "R6", cnt, 0);
        @(negedge clk);
        check(req_ready == 1'b1 && seg_done == 1'b0, "R8", {req_ready, seg_done}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(req_ready && !chk_valid && !seg_done && !erase_need, "R1",
              {req_ready, chk_valid, seg_done, erase_need}, 4'b1000);

        for (int i = 0; i < NV; i++) run_req(VEC[i][39:16], VEC[i][15:0]);

        // back-pressure and busy request: R7, R8
        @(negedge clk);
        chk_ready = 1'b0;
        req_valid = 1'b1; req_addr = 24'h000010; req_len = 16'd300;
        @(negedge clk);
        req_addr = 24'h0ABC00; req_len = 16'd5;
        for (int k = 0; k < 3; k++) begin
            check(chk_valid && chk_addr == 24'h000010 && chk_len == 9'd240, "R7",
                  {chk_addr, chk_len}, {24'h000010, 9'd240});
            check(!req_ready, "R8", req_ready, 0);
            @(negedge clk);
        end
        chk_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(chk_valid && chk_addr == 24'h000100 && chk_len == 9'd60 && chk_last, "R8",
              {chk_addr, chk_len, chk_last}, {24'h000100, 9'd60, 1'b1});
        @(negedge clk);
        check(seg_done && !chk_valid, "R5", {seg_done, chk_valid}, 2'b10);
        @(negedge clk);

        // blank checker
        scan_clr = 1'b1; @(negedge clk); scan_clr = 1'b0;
        scan_vld = 1'b1; scan_inwin = 1'b1; scan_data = 8'hFF;
        @(negedge clk);
        check(!erase_need, "R11", erase_need, 0);
        scan_inwin = 1'b0; scan_data = 8'h00;
        @(negedge clk);
        check(!erase_need, "R11", erase_need, 0);
        scan_inwin = 1'b1; scan_data = 8'h7E;
        @(negedge clk);
        check(erase_need, "R10", erase_need, 1);
        scan_data = 8'hFF;
        @(negedge clk);
        check(erase_need, "R10", erase_need, 1);
        scan_clr = 1'b1; scan_data = 8'h01;
        @(negedge clk);
        check(!erase_need, "R10", erase_need, 0);
        scan_clr = 1'b0; scan_vld = 1'b0;
        @(negedge clk);
        check(!erase_need, "R11", erase_need, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule